// File: doc/BRIEF.md
# ATM Virtual-Circuit Cell Splitter

This block sits directly on an octet-parallel ATM receive stream, with no queue ahead of it, and sorts each incoming 53-octet cell by virtual circuit. The circuit identifier of each cell is compared with a configured target. A cell on the target circuit is split: its five header octets go out on a header side channel that carries them to a later cell-rebuild stage, and its 48 payload octets go out on a payload port that feeds the processing pipeline. Any other cell leaves whole, header included and unchanged, on a bypass port. A mode input narrows the comparison to the path identifier (VPI) alone.

The input cannot be stalled. Octets arrive at most one per clock, qualified by a valid strobe, and a start marker flags the first octet of each cell. The routing decision is taken when the fourth octet arrives, because that octet completes the channel identifier (VCI). A small internal ring holds octets until the decision is known and then drains them at one octet per clock. Each output port is a valid/ready stream with an end-of-cell flag on its final octet. Ready works as a credit for a whole cell. It is sampled only at the decision, and a high value promises room for one complete cell. After a cell is committed its octets are presented with valid, and ready is not consulted again for that cell. When the chosen destination is not ready at the decision, the whole cell is discarded and a drop counter advances.

Top module: `atm_vc_splitter`

## Requirements
- R1: Out of reset, no output valid is asserted and the drop counter reads zero.
- R2: Cell octet 0 bits [3:0] and octet 1 bits [7:4] form the 8-bit VPI. Octet 1 bits [3:0], octet 2, and octet 3 bits [7:4] form the 16-bit VCI (octet 0 is the one marked with in_sof). With cfg_vpi_only low, a cell whose VPI and VCI both equal cfg_vpi and cfg_vci is treated as boosted, and any other cell as bypass.
- R3: For a boosted cell, header octets 0 to 4 (including the fifth, check octet) appear on the header port in arrival order, with hdr_eoc set only on the fifth.
- R4: For a boosted cell, payload octets 5 to 52 appear on the payload port in arrival order, with pay_eoc set only on the 48th.
- R5: A bypass cell appears on the bypass port as all 53 octets, unchanged and in order, with byp_eoc set only on the 53rd. Nothing of it appears on the other two ports.
- R6: With cfg_vpi_only high, a cell is boosted when its VPI equals cfg_vpi, whatever its VCI.
- R7: The ready inputs are sampled on the clock edge that accepts octet 3. A boosted cell needs pay_ready and hdr_ready both high, and a bypass cell needs byp_ready high. Otherwise no octet of the cell appears on any port, and drop_count rises by exactly one.
- R8: Once a cell is committed, dropping ready later in that cell does not stop or cut short its output, and drop_count is unchanged.
- R9: Idle cycles between input octets and back-to-back cells without gaps are both carried without loss or reordering.
- R10: Valid octets that do not belong to a cell are ignored. This covers octets before the first in_sof, and octets after a cell's 53rd octet that arrive before the next in_sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input octet present this cycle |
| in_sof | input | 1 | Marks octet 0 of a cell |
| in_data | input | 8 | Input octet |
| cfg_vpi | input | 8 | Target path identifier |
| cfg_vci | input | 16 | Target channel identifier |
| cfg_vpi_only | input | 1 | Match on VPI alone |
| pay_valid | output | 1 | Payload octet valid |
| pay_ready | input | 1 | Payload sink has room for a full cell |
| pay_data | output | 8 | Payload octet |
| pay_eoc | output | 1 | Last payload octet of the cell |
| hdr_valid | output | 1 | Header octet valid |
| hdr_ready | input | 1 | Header sink has room for a full header |
| hdr_data | output | 8 | Header octet |
| hdr_eoc | output | 1 | Last header octet of the cell |
| byp_valid | output | 1 | Bypass octet valid |
| byp_ready | input | 1 | Bypass sink has room for a full cell |
| byp_data | output | 8 | Bypass octet |
| byp_eoc | output | 1 | Last octet of a bypassed cell |
| drop_count | output | 16 | Count of cells discarded for lack of room |

## Verification
The assertions assume a well-formed line. in_sof appears only on the first octet of a cell, and never while a cell is still short of its 53 octets. The configuration inputs are steady around the decision edge. Under those conditions the end-of-cell flags land at fixed octet counts on each port, and the internal ring never fills. The stimulus always sends complete cells and puts stray octets only outside cells. It changes configuration and ready only between cells, except in the test that lowers ready deliberately after the decision.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int CELL_LEN   = 53;
  localparam int HDR_LEN    = 5;
  localparam int DECIDE_POS = 3;
  localparam int POS_W      = $clog2(CELL_LEN);

  typedef enum logic [1:0] {
    DST_NONE   = 2'd0,
    DST_DROP   = 2'd1,
    DST_BOOST  = 2'd2,
    DST_BYPASS = 2'd3
  } dst_e;

  typedef struct packed {
    logic [7:0]       data;
    logic [POS_W-1:0] pos;
    logic             tag;
  } oct_t;
endpackage

// File: rtl/vcs_tracker.sv
module vcs_tracker
  import vcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_data,
  input  logic [7:0]  cfg_vpi,
  input  logic [15:0] cfg_vci,
  input  logic        cfg_vpi_only,
  input  logic        pay_ready,
  input  logic        hdr_ready,
  input  logic        byp_ready,
  output logic        wr_en,
  output oct_t        wr_oct,
  output logic        dec_en,
  output logic        dec_tag,
  output dst_e        dec_dst
);
  logic             in_cell_q;
  logic [POS_W-1:0] pos_q;
  logic             tag_q;
  logic [7:0]       stage_q [DECIDE_POS];

  logic             accept;
  logic [POS_W-1:0] cur_pos;
  logic             cur_tag;
  logic [7:0]       cell_vpi;
  logic [15:0]      cell_vci;
  logic             hit;

  always_comb begin
    cur_pos = in_sof ? '0 : pos_q + 1'b1;
    cur_tag = in_sof ? ~tag_q : tag_q;
    accept  = in_valid && (in_sof || (in_cell_q && pos_q != POS_W'(CELL_LEN-1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cell_q <= 1'b0;
      pos_q     <= '0;
      tag_q     <= 1'b0;
    end else if (accept) begin
      in_cell_q <= 1'b1;
      pos_q     <= cur_pos;
      tag_q     <= cur_tag;
    end
  end

  // early header octets are held until the circuit decision
  always_ff @(posedge clk) begin
    for (int i = 0; i < DECIDE_POS; i++) begin
      if (accept && cur_pos == POS_W'(i)) stage_q[i] <= in_data;
    end
  end

  always_comb begin
    cell_vpi = {stage_q[0][3:0], stage_q[1][7:4]};
    cell_vci = {stage_q[1][3:0], stage_q[2], in_data[7:4]};
    hit      = (cell_vpi == cfg_vpi) && (cfg_vpi_only || cell_vci == cfg_vci);
    if (hit) dec_dst = (pay_ready && hdr_ready) ? DST_BOOST : DST_DROP;
    else     dec_dst = byp_ready ? DST_BYPASS : DST_DROP;
    wr_en       = accept;
    wr_oct.data = in_data;
    wr_oct.pos  = cur_pos;
    wr_oct.tag  = cur_tag;
    dec_en      = accept && cur_pos == POS_W'(DECIDE_POS);
    dec_tag     = cur_tag;
  end
endmodule

// File: rtl/vcs_ring.sv
module vcs_ring
  import vcs_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  oct_t        push_oct,
  input  logic        pop,
  output oct_t        head,
  output logic [AW:0] level
);
  localparam int DEPTH = 1 << AW;

  oct_t          mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   lvl_q;

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= push_oct;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign head  = mem_q[rp_q];
  assign level = lvl_q;
endmodule

// File: rtl/vcs_router.sv
module vcs_router
  import vcs_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_en,
  input  logic        dec_tag,
  input  dst_e        dec_dst,
  input  oct_t        head,
  input  logic [AW:0] level,
  output logic        pop,
  output logic        pay_valid,
  output logic [7:0]  pay_data,
  output logic        pay_eoc,
  output logic        hdr_valid,
  output logic [7:0]  hdr_data,
  output logic        hdr_eoc,
  output logic        byp_valid,
  output logic [7:0]  byp_data,
  output logic        byp_eoc
);
  dst_e       slot_q [2];
  dst_e       cur_dst;
  logic       last;
  logic [7:0] data_q;
  logic       hdr_end_q, cell_end_q;

  always_comb begin
    cur_dst = slot_q[head.tag];
    last    = head.pos == POS_W'(CELL_LEN-1);
    pop     = (level != '0) && (cur_dst != DST_NONE);
  end

  // one decision slot per in-flight cell, freed when its last octet leaves
  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (!rst_n)                                  slot_q[s] <= DST_NONE;
      else if (dec_en && dec_tag == 1'(s))         slot_q[s] <= dec_dst;
      else if (pop && last && head.tag == 1'(s))   slot_q[s] <= DST_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_valid <= 1'b0;
      hdr_valid <= 1'b0;
      byp_valid <= 1'b0;
    end else begin
      hdr_valid <= pop && cur_dst == DST_BOOST && head.pos <  POS_W'(HDR_LEN);
      pay_valid <= pop && cur_dst == DST_BOOST && head.pos >= POS_W'(HDR_LEN);
      byp_valid <= pop && cur_dst == DST_BYPASS;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      data_q     <= head.data;
      hdr_end_q  <= head.pos == POS_W'(HDR_LEN-1);
      cell_end_q <= last;
    end
  end

  assign pay_data = data_q;
  assign hdr_data = data_q;
  assign byp_data = data_q;
  assign pay_eoc  = cell_end_q;
  assign hdr_eoc  = hdr_end_q;
  assign byp_eoc  = cell_end_q;
endmodule

// File: rtl/atm_vc_splitter.sv
module atm_vc_splitter
  import vcs_pkg::*;
#(
  parameter int RING_AW = 3,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic [7:0]       cfg_vpi,
  input  logic [15:0]      cfg_vci,
  input  logic             cfg_vpi_only,
  output logic             pay_valid,
  input  logic             pay_ready,
  output logic [7:0]       pay_data,
  output logic             pay_eoc,
  output logic             hdr_valid,
  input  logic             hdr_ready,
  output logic [7:0]       hdr_data,
  output logic             hdr_eoc,
  output logic             byp_valid,
  input  logic             byp_ready,
  output logic [7:0]       byp_data,
  output logic             byp_eoc,
  output logic [CNT_W-1:0] drop_count
);
  logic             wr_en, dec_en, dec_tag, pop;
  oct_t             wr_oct, head;
  dst_e             dec_dst;
  logic [RING_AW:0] ring_level;
  logic [CNT_W-1:0] drop_q;

  vcs_tracker u_trk (
    .clk, .rst_n, .in_valid, .in_sof, .in_data,
    .cfg_vpi, .cfg_vci, .cfg_vpi_only,
    .pay_ready, .hdr_ready, .byp_ready,
    .wr_en, .wr_oct, .dec_en, .dec_tag, .dec_dst
  );

  vcs_ring #(.AW(RING_AW)) u_ring (
    .clk, .rst_n, .push(wr_en), .push_oct(wr_oct), .pop,
    .head, .level(ring_level)
  );

  vcs_router #(.AW(RING_AW)) u_rtr (
    .clk, .rst_n, .dec_en, .dec_tag, .dec_dst, .head, .level(ring_level),
    .pop,
    .pay_valid, .pay_data, .pay_eoc,
    .hdr_valid, .hdr_data, .hdr_eoc,
    .byp_valid, .byp_data, .byp_eoc
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                            drop_q <= '0;
    else if (dec_en && dec_dst == DST_DROP) drop_q <= drop_q + 1'b1;
  end

  assign drop_count = drop_q;
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
  parameter int RING_AW = 3,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pay_valid,
  input logic             pay_eoc,
  input logic             hdr_valid,
  input logic             hdr_eoc,
  input logic             byp_valid,
  input logic             byp_eoc,
  input logic [CNT_W-1:0] drop_count,
  input logic [RING_AW:0] ring_level
);
  logic [5:0] hdr_n, pay_n, byp_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_n <= '0;
      pay_n <= '0;
      byp_n <= '0;
    end else begin
      if (hdr_valid) hdr_n <= hdr_eoc ? 6'd0 : hdr_n + 6'd1;
      if (pay_valid) pay_n <= pay_eoc ? 6'd0 : pay_n + 6'd1;
      if (byp_valid) byp_n <= byp_eoc ? 6'd0 : byp_n + 6'd1;
    end
  end

  AST_HDR_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (hdr_eoc == (hdr_n == 6'd4))); // R3
  AST_PAY_FORTYEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (pay_eoc == (pay_n == 6'd47))); // R4
  AST_BYP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid |-> (byp_eoc == (byp_n == 6'd52))); // R5
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1)); // R7
  AST_RING_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ring_level) < (1 << RING_AW)); // R9
endmodule

bind atm_vc_splitter vcs_checker #(.RING_AW(RING_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pay_valid(pay_valid), .pay_eoc(pay_eoc),
  .hdr_valid(hdr_valid), .hdr_eoc(hdr_eoc),
  .byp_valid(byp_valid), .byp_eoc(byp_eoc),
  .drop_count(drop_count), .ring_level(ring_level)
);

// File: tb/atm_vc_splitter_tb.sv
module atm_vc_splitter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_sof, cfg_vpi_only;
  logic [7:0]  in_data, cfg_vpi;
  logic [15:0] cfg_vci;
  logic        pay_valid, pay_ready, pay_eoc, hdr_valid, hdr_ready, hdr_eoc;
  logic        byp_valid, byp_ready, byp_eoc;
  logic [7:0]  pay_data, hdr_data, byp_data;
  logic [15:0] drop_count;

  atm_vc_splitter u_dut (
    .clk, .rst_n, .in_valid, .in_sof, .in_data,
    .cfg_vpi, .cfg_vci, .cfg_vpi_only,
    .pay_valid, .pay_ready, .pay_data, .pay_eoc,
    .hdr_valid, .hdr_ready, .hdr_data, .hdr_eoc,
    .byp_valid, .byp_ready, .byp_data, .byp_eoc,
    .drop_count
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [8:0] hdr_log [2048];
  logic [8:0] pay_log [2048];
  logic [8:0] byp_log [2048];
  int hdr_n = 0, pay_n = 0, byp_n = 0;

  always @(negedge clk) begin
    if (hdr_valid) begin hdr_log[hdr_n] = {hdr_eoc, hdr_data}; hdr_n++; end
    if (pay_valid) begin pay_log[pay_n] = {pay_eoc, pay_data}; pay_n++; end
    if (byp_valid) begin byp_log[byp_n] = {byp_eoc, byp_data}; byp_n++; end
  end

  // route codes: 0 dropped, 1 boosted, 2 bypassed, 3 malformed
  // vector: vpi, vci, cfg_vpi, cfg_vci, vpi_only, pay_rdy, hdr_rdy, byp_rdy, route
  localparam logic [53:0] VEC [10] = '{
    {8'h12, 16'h0345, 8'h12, 16'h0345, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1},
    {8'h12, 16'h0346, 8'h12, 16'h0345, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2},
    {8'h13, 16'h0345, 8'h12, 16'h0345, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2},
    {8'h12, 16'h0999, 8'h12, 16'h0345, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1},
    {8'h22, 16'h0345, 8'h12, 16'h0345, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2},
    {8'h12, 16'h0345, 8'h12, 16'h0345, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0},
    {8'h12, 16'h0345, 8'h12, 16'h0345, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    {8'h40, 16'h0001, 8'h12, 16'h0345, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    {8'h40, 16'h0001, 8'h12, 16'h0345, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
    {8'h12, 16'h1345, 8'h12, 16'h0345, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cell_octet(input int idx, input logic [7:0] vpi,
                                            input logic [15:0] vci, input int seed);
    case (idx)
      0:       return {4'(seed), vpi[7:4]};
      1:       return {vpi[3:0], vci[15:12]};
      2:       return vci[11:4];
      3:       return {vci[3:0], 3'(seed), 1'b0};
      4:       return 8'hA5 ^ 8'(seed);
      default: return 8'(seed * 7 + idx * 13);
    endcase
  endfunction

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cell(input logic [7:0] vpi, input logic [15:0] vci, input int seed,
                           input bit gaps, input bit flip, input int stray);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_data = cell_octet(i, vpi, vci, seed);
      if (flip && i == 4) begin pay_ready = 1'b0; hdr_ready = 1'b0; byp_ready = 1'b0; end
      if (gaps && (i % 4 == 2)) begin @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; end
    end
    for (int k = 0; k < stray; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_data = cell_octet(3, vpi, vci, seed);
    end
  endtask

  task automatic check_contents(input int dst, input logic [7:0] vpi, input logic [15:0] vci,
                                input int seed, input int h0, input int p0, input int b0);
    int bad;
    if (dst == 1) begin
      bad = 0;
      for (int i = 0; i < 5; i++)
        if (hdr_log[h0+i] != {i == 4, cell_octet(i, vpi, vci, seed)}) bad++;
      chk(bad == 0, "R3", "header octets/eoc mismatches", bad, 0);
      bad = 0;
      for (int i = 0; i < 48; i++)
        if (pay_log[p0+i] != {i == 47, cell_octet(i + 5, vpi, vci, seed)}) bad++;
      chk(bad == 0, "R4", "payload octets/eoc mismatches", bad, 0);
    end else if (dst == 2) begin
      bad = 0;
      for (int i = 0; i < 53; i++)
        if (byp_log[b0+i] != {i == 52, cell_octet(i, vpi, vci, seed)}) bad++;
      chk(bad == 0, "R5", "bypass octets/eoc mismatches", bad, 0);
    end
  endtask

  task automatic run_cell(input logic [7:0] vpi, input logic [15:0] vci, input int seed,
                          input int dst, input string rtag, input bit gaps, input bit flip,
                          input int stray);
    int h0 = hdr_n;
    int p0 = pay_n;
    int b0 = byp_n;
    int got;
    send_cell(vpi, vci, seed, gaps, flip, stray);
    idle(14);
    if (hdr_n - h0 == 5 && pay_n - p0 == 48 && byp_n == b0)        got = 1;
    else if (byp_n - b0 == 53 && hdr_n == h0 && pay_n == p0)       got = 2;
    else if (byp_n == b0 && hdr_n == h0 && pay_n == p0)            got = 0;
    else                                                           got = 3;
    chk(got == dst, rtag, "route", got, dst);
    check_contents(dst, vpi, vci, seed, h0, p0, b0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int h0, p0, b0, d0;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h00;
    cfg_vpi = 8'h12; cfg_vci = 16'h0345; cfg_vpi_only = 1'b0;
    pay_ready = 1'b1; hdr_ready = 1'b1; byp_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({pay_valid, hdr_valid, byp_valid} == 3'b000, "R1", "valids after reset",
        {pay_valid, hdr_valid, byp_valid}, 0);
    chk(drop_count == 16'd0, "R1", "drop_count after reset", drop_count, 0);

    // R10: valid octets before any start marker
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_data = 8'h12;
    end
    idle(10);
    chk(hdr_n + pay_n + byp_n == 0, "R10", "octets out before first sof",
        hdr_n + pay_n + byp_n, 0);

    // table walk: R2 R5 R6 R7 routing
    for (int r = 0; r < 10; r++) begin
      cfg_vpi      = VEC[r][29:22];
      cfg_vci      = VEC[r][21:6];
      cfg_vpi_only = VEC[r][5];
      pay_ready    = VEC[r][4];
      hdr_ready    = VEC[r][3];
      byp_ready    = VEC[r][2];
      run_cell(VEC[r][53:46], VEC[r][45:30], 16 + r, int'(VEC[r][1:0]),
               VEC[r][5] ? "R6" : (VEC[r][1:0] == 2'd0 ? "R7" : "R2"), 1'b0, 1'b0, 0);
      pay_ready = 1'b1; hdr_ready = 1'b1; byp_ready = 1'b1;
    end
    chk(drop_count == 16'd3, "R7", "drop_count after table", drop_count, 3);

    cfg_vpi = 8'h12; cfg_vci = 16'h0345; cfg_vpi_only = 1'b0;

    // R8: readies fall after the decision
    d0 = drop_count;
    run_cell(8'h12, 16'h0345, 40, 1, "R8", 1'b0, 1'b1, 0);
    chk(drop_count == 16'(d0), "R8", "drop_count after late ready drop", drop_count, d0);
    pay_ready = 1'b1; hdr_ready = 1'b1; byp_ready = 1'b1;
    run_cell(8'h55, 16'h0777, 41, 2, "R8", 1'b0, 1'b1, 0);
    pay_ready = 1'b1; hdr_ready = 1'b1; byp_ready = 1'b1;

    // R9: gapped input
    run_cell(8'h12, 16'h0345, 50, 1, "R9", 1'b1, 1'b0, 0);
    run_cell(8'h77, 16'h0345, 51, 2, "R9", 1'b1, 1'b0, 0);

    // R9: back-to-back cells without idle
    h0 = hdr_n; p0 = pay_n; b0 = byp_n;
    send_cell(8'h12, 16'h0345, 60, 1'b0, 1'b0, 0);
    send_cell(8'h34, 16'h0345, 61, 1'b0, 1'b0, 0);
    send_cell(8'h12, 16'h0345, 62, 1'b0, 1'b0, 0);
    idle(14);
    chk(hdr_n - h0 == 10 && pay_n - p0 == 96 && byp_n - b0 == 53, "R9",
        "back-to-back octet total", (hdr_n - h0) + (pay_n - p0) + (byp_n - b0), 159);
    check_contents(1, 8'h12, 16'h0345, 60, h0, p0, b0);
    check_contents(2, 8'h34, 16'h0345, 61, h0, p0, b0);
    check_contents(1, 8'h12, 16'h0345, 62, h0 + 5, p0 + 48, b0);

    // R10: stray octets after a complete cell
    run_cell(8'h12, 16'h0345, 70, 1, "R10", 1'b0, 1'b0, 7);
    run_cell(8'h19, 16'h0345, 71, 2, "R10", 1'b0, 1'b0, 5);

    finish_run();
  end
endmodule